// File: doc/BRIEF.md
# Trap Return Unit

This unit carries out the two trap-return operations of a processor core: the return from a machine-level handler and the return from a supervisor-level handler. When the pipeline presents a return request, the unit takes the current privilege level, the interrupt-enable stack fields of the status register, both saved exception program counters and a flag saying whether compressed (16-bit) instructions are supported. One clock later it reports either a committed return or an exception.

A committed return gives the address to resume at, the privilege level to enter and the rewritten status fields. A return issued from too low a privilege level is reported as an illegal instruction. A resume address that cannot be fetched on a core without compressed instructions is reported as a misaligned instruction address. The surrounding core writes the reported state into its architectural registers only when the commit flag is set. Trap entry and vector computation are handled elsewhere.

Top module: `trp_return_unit`

## Requirements
- R1: A machine return (`ret_sret`=0) is illegal unless `cur_priv` is 2'b11 (machine); an illegal return sets `rsp_illegal` and clears `rsp_commit`.
- R2: A supervisor return (`ret_sret`=1) is illegal when `cur_priv` is 2'b00 (user) and legal at 2'b01, 2'b10 or 2'b11.
- R3: `rsp_pc` carries `mepc` for a machine return and `sepc` for a supervisor return, whether or not the return commits.
- R4: When `rvc_en` is 0 and bits [1:0] of the selected return address are not both zero, `rsp_misaligned` is set and the return does not commit; when `rvc_en` is 1 no alignment fault is raised.
- R5: A privilege fault takes priority over an alignment fault: `rsp_illegal` and `rsp_misaligned` are never set together.
- R6: A committed machine return gives `rsp_mie` = old `st_mpie`, `rsp_mpie` = 0, `rsp_mpp` = 2'b00, and passes the supervisor fields through unchanged.
- R7: A committed supervisor return gives `rsp_sie` = old `st_spie`, `rsp_spie` = 0, `rsp_spp` = 0, and passes the machine fields through unchanged.
- R8: A committed machine return enters the level held in `st_mpp`, except that the value 2'b10 enters user (2'b00); a committed supervisor return enters 2'b01 when `st_spp` is 1 and 2'b00 when it is 0.
- R9: A return that raises either exception reports `rsp_priv` equal to `cur_priv` and every status output equal to its input, so no state changes.
- R10: The response appears in the cycle after the request; `rsp_valid`, `rsp_commit`, `rsp_illegal` and `rsp_misaligned` are 0 in every cycle that follows no request. After reset `rsp_valid` is 0, `rsp_priv` is 2'b11 and every status output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_valid | input | 1 | A return request is present this cycle |
| ret_sret | input | 1 | 1 selects the supervisor return, 0 the machine return |
| cur_priv | input | 2 | Current privilege level (U=00, S=01, H=10, M=11) |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege (0=U, 1=S) |
| mepc | input | XLEN | Saved machine exception address |
| sepc | input | XLEN | Saved supervisor exception address |
| rvc_en | input | 1 | Compressed instructions supported |
| rsp_valid | output | 1 | Response present |
| rsp_commit | output | 1 | Return completes without exception |
| rsp_illegal | output | 1 | Illegal instruction raised |
| rsp_misaligned | output | 1 | Instruction address misaligned raised |
| rsp_pc | output | XLEN | Selected return address |
| rsp_priv | output | 2 | Privilege level after the operation |
| rsp_mie | output | 1 | Resulting machine interrupt enable |
| rsp_mpie | output | 1 | Resulting machine previous interrupt enable |
| rsp_mpp | output | 2 | Resulting machine previous privilege |
| rsp_sie | output | 1 | Resulting supervisor interrupt enable |
| rsp_spie | output | 1 | Resulting supervisor previous interrupt enable |
| rsp_spp | output | 1 | Resulting supervisor previous privilege |

## Verification
The privilege check and the alignment check can both fail on the same request. The bench provokes this with returns issued from too low a level while the selected saved address has non-zero low bits and compressed support is off, for both return kinds. The scoreboard expects only the illegal-instruction flag, the commit flag clear and all status and privilege outputs equal to their inputs, and the sweep repeats the overlap across every privilege and previous-privilege combination.

// File: rtl/trp_pkg.sv
package trp_pkg;

    typedef enum logic [1:0] {
        LVL_U = 2'b00,
        LVL_S = 2'b01,
        LVL_H = 2'b10,
        LVL_M = 2'b11
    } lvl_e;

    typedef enum logic {
        RET_M = 1'b0,
        RET_S = 1'b1
    } ret_kind_e;

    typedef struct packed {
        logic m_ie;
        logic m_pie;
        lvl_e m_pp;
        logic s_ie;
        logic s_pie;
        logic s_pp;
    } stat_t;

    localparam stat_t STAT_RST = '{
        m_ie: 1'b0, m_pie: 1'b0, m_pp: LVL_U,
        s_ie: 1'b0, s_pie: 1'b0, s_pp: 1'b0
    };

    // The hypervisor level does not exist here; it lands in user mode.
    function automatic lvl_e fold_level(lvl_e l);
        return (l == LVL_H) ? LVL_U : l;
    endfunction

endpackage

// File: rtl/trp_legal.sv
module trp_legal
    import trp_pkg::*;
(
    input  ret_kind_e kind,
    input  lvl_e      cur,
    output logic      illegal
);
    always_comb begin
        unique case (kind)
            RET_M:   illegal = (cur != LVL_M);
            RET_S:   illegal = (cur == LVL_U);
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/trp_align.sv
module trp_align #(
    parameter int STRICT_BITS = 2
) (
    input  logic [1:0] pc_lo,
    input  logic       rvc_en,
    output logic       misaligned
);
    generate
        if (STRICT_BITS >= 2) begin : g_word
            assign misaligned = !rvc_en && (pc_lo != 2'b00);
        end else begin : g_half
            logic unused_hi;
            assign unused_hi  = pc_lo[1];
            assign misaligned = !rvc_en && pc_lo[0];
        end
    endgenerate
endmodule

// File: rtl/trp_status.sv
module trp_status
    import trp_pkg::*;
(
    input  ret_kind_e kind,
    input  stat_t     cur,
    output stat_t     nxt,
    output lvl_e      dest
);
    always_comb begin
        nxt  = cur;
        dest = LVL_U;
        unique case (kind)
            RET_M: begin
                dest      = fold_level(cur.m_pp);
                nxt.m_ie  = cur.m_pie;
                nxt.m_pie = 1'b0;
                nxt.m_pp  = LVL_U;
            end
            RET_S: begin
                dest      = cur.s_pp ? LVL_S : LVL_U;
                nxt.s_ie  = cur.s_pie;
                nxt.s_pie = 1'b0;
                nxt.s_pp  = 1'b0;
            end
            default: begin
                nxt  = cur;
                dest = LVL_U;
            end
        endcase
    end
endmodule

// File: rtl/trp_return_unit.sv
module trp_return_unit
    import trp_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int STRICT_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    input  logic            ret_sret,
    input  logic [1:0]      cur_priv,
    input  logic            st_mie,
    input  logic            st_mpie,
    input  logic [1:0]      st_mpp,
    input  logic            st_sie,
    input  logic            st_spie,
    input  logic            st_spp,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    input  logic            rvc_en,
    output logic            rsp_valid,
    output logic            rsp_commit,
    output logic            rsp_illegal,
    output logic            rsp_misaligned,
    output logic [XLEN-1:0] rsp_pc,
    output logic [1:0]      rsp_priv,
    output logic            rsp_mie,
    output logic            rsp_mpie,
    output logic [1:0]      rsp_mpp,
    output logic            rsp_sie,
    output logic            rsp_spie,
    output logic            rsp_spp
);
    typedef struct packed {
        logic  valid;
        logic  commit;
        logic  illegal;
        logic  misaligned;
        lvl_e  level;
        stat_t st;
    } rsp_t;

    localparam rsp_t RSP_RST = '{
        valid: 1'b0, commit: 1'b0, illegal: 1'b0, misaligned: 1'b0,
        level: LVL_M, st: STAT_RST
    };

    rsp_t            rsp_d, rsp_q;
    logic [XLEN-1:0] pc_d, pc_q;

    ret_kind_e       kind;
    lvl_e            cur_lvl;
    stat_t           st_in, st_nxt;
    lvl_e            dest_lvl;
    logic [XLEN-1:0] target_pc;
    logic            priv_fault, align_fault;

    assign kind      = ret_sret ? RET_S : RET_M;
    assign cur_lvl   = lvl_e'(cur_priv);
    assign st_in     = '{m_ie: st_mie, m_pie: st_mpie, m_pp: lvl_e'(st_mpp),
                         s_ie: st_sie, s_pie: st_spie, s_pp: st_spp};
    assign target_pc = (kind == RET_S) ? sepc : mepc;

    trp_legal u_legal (
        .kind    (kind),
        .cur     (cur_lvl),
        .illegal (priv_fault)
    );

    trp_align #(.STRICT_BITS(STRICT_BITS)) u_align (
        .pc_lo      (target_pc[1:0]),
        .rvc_en     (rvc_en),
        .misaligned (align_fault)
    );

    trp_status u_status (
        .kind (kind),
        .cur  (st_in),
        .nxt  (st_nxt),
        .dest (dest_lvl)
    );

    always_comb begin
        rsp_d            = rsp_q;
        pc_d             = pc_q;
        rsp_d.valid      = 1'b0;
        rsp_d.commit     = 1'b0;
        rsp_d.illegal    = 1'b0;
        rsp_d.misaligned = 1'b0;
        if (ret_valid) begin
            rsp_d.valid      = 1'b1;
            rsp_d.illegal    = priv_fault;
            rsp_d.misaligned = !priv_fault && align_fault;
            rsp_d.commit     = !priv_fault && !align_fault;
            pc_d             = target_pc;
            if (!priv_fault && !align_fault) begin
                rsp_d.level = dest_lvl;
                rsp_d.st    = st_nxt;
            end else begin
                rsp_d.level = cur_lvl;
                rsp_d.st    = st_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= RSP_RST;
            pc_q  <= '0;
        end else begin
            rsp_q <= rsp_d;
            pc_q  <= pc_d;
        end
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_commit     = rsp_q.commit;
    assign rsp_illegal    = rsp_q.illegal;
    assign rsp_misaligned = rsp_q.misaligned;
    assign rsp_pc         = pc_q;
    assign rsp_priv       = rsp_q.level;
    assign rsp_mie        = rsp_q.st.m_ie;
    assign rsp_mpie       = rsp_q.st.m_pie;
    assign rsp_mpp        = rsp_q.st.m_pp;
    assign rsp_sie        = rsp_q.st.s_ie;
    assign rsp_spie       = rsp_q.st.s_pie;
    assign rsp_spp        = rsp_q.st.s_pp;

endmodule

// File: rtl/trp_return_chk.sv
module trp_return_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_valid,
    input logic            ret_sret,
    input logic [1:0]      cur_priv,
    input logic            st_mie,
    input logic            st_mpie,
    input logic [1:0]      st_mpp,
    input logic            st_sie,
    input logic            st_spie,
    input logic            st_spp,
    input logic [XLEN-1:0] mepc,
    input logic [XLEN-1:0] sepc,
    input logic            rvc_en,
    input logic            rsp_valid,
    input logic            rsp_commit,
    input logic            rsp_illegal,
    input logic            rsp_misaligned,
    input logic [XLEN-1:0] rsp_pc,
    input logic [1:0]      rsp_priv,
    input logic            rsp_mie,
    input logic            rsp_mpie,
    input logic [1:0]      rsp_mpp,
    input logic            rsp_sie,
    input logic            rsp_spie,
    input logic            rsp_spp
);
    p_mret_priv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_sret && cur_priv != 2'b11) |=> (rsp_illegal && !rsp_commit));

    p_sret_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_sret && cur_priv == 2'b00) |=> (rsp_illegal && !rsp_commit));

    p_mret_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_sret) |=> (rsp_pc == $past(mepc)));

    p_sret_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_sret) |=> (rsp_pc == $past(sepc)));

    p_rvc_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && rvc_en) |=> !rsp_misaligned);

    p_fault_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_illegal && rsp_misaligned));

    p_mret_stack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_sret && cur_priv == 2'b11 && (rvc_en || mepc[1:0] == 2'b00))
        |=> (rsp_commit && rsp_mie == $past(st_mpie) && !rsp_mpie && rsp_mpp == 2'b00
             && rsp_sie == $past(st_sie) && rsp_spie == $past(st_spie)));

    p_sret_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_sret && cur_priv != 2'b00 && (rvc_en || sepc[1:0] == 2'b00))
        |=> (rsp_commit && rsp_sie == $past(st_spie) && !rsp_spie && !rsp_spp
             && rsp_mie == $past(st_mie) && rsp_mpp == $past(st_mpp)));

    p_h_remap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_sret && cur_priv == 2'b11 && st_mpp == 2'b10 && rvc_en)
        |=> (rsp_priv == 2'b00));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && cur_priv == 2'b00)
        |=> (rsp_priv == $past(cur_priv) && rsp_mie == $past(st_mie)
             && rsp_mpie == $past(st_mpie) && rsp_mpp == $past(st_mpp)
             && rsp_sie == $past(st_sie) && rsp_spie == $past(st_spie)
             && rsp_spp == $past(st_spp)));

    p_resp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> rsp_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> (!rsp_valid && !rsp_commit && !rsp_illegal && !rsp_misaligned));

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_commit, rsp_illegal, rsp_misaligned}));
endmodule

bind trp_return_unit trp_return_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_trp_return_unit.sv
module test_trp_return_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ret_valid = 1'b0, ret_sret = 1'b0;
    logic [1:0]      cur_priv = 2'b00;
    logic            st_mie = 1'b0, st_mpie = 1'b0, st_sie = 1'b0, st_spie = 1'b0, st_spp = 1'b0;
    logic [1:0]      st_mpp = 2'b00;
    logic [XLEN-1:0] mepc = '0, sepc = '0;
    logic            rvc_en = 1'b0;
    logic            rsp_valid, rsp_commit, rsp_illegal, rsp_misaligned;
    logic [XLEN-1:0] rsp_pc;
    logic [1:0]      rsp_priv, rsp_mpp;
    logic            rsp_mie, rsp_mpie, rsp_sie, rsp_spie, rsp_spp;

    always #5 clk = ~clk;

    trp_return_unit #(.XLEN(XLEN)) i_trp_return_unit (.*);

    typedef struct packed {
        logic [2:0]      flags;   // commit, illegal, misaligned
        logic [XLEN-1:0] pc;
        logic [1:0]      lvl;
        logic [6:0]      st;      // mie, mpie, mpp, sie, spie, spp
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request at the falling edge and predict its response.
    task automatic issue(input bit s, input logic [1:0] lvl, input logic [6:0] st,
                         input logic [XLEN-1:0] mp, input logic [XLEN-1:0] sp, input bit rvc);
        exp_t e;
        logic [XLEN-1:0] tgt;
        bit ill, mis;
        @(negedge clk);
        ret_valid = 1'b1; ret_sret = s; cur_priv = lvl;
        {st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp} = st;
        mepc = mp; sepc = sp; rvc_en = rvc;
        ill = s ? (lvl == 2'b00) : (lvl != 2'b11);             // R1 R2
        tgt = s ? sp : mp;                                       // R3
        mis = !ill && !rvc && (tgt[1:0] != 2'b00);              // R4 R5
        e.flags = {!ill && !mis, ill, mis};
        e.pc    = tgt;
        e.lvl   = lvl;                                           // R9
        e.st    = st;
        if (!ill && !mis) begin
            if (!s) begin                                        // R6 R8
                e.lvl = (st[4:3] == 2'b10) ? 2'b00 : st[4:3];
                e.st  = {st[5], 1'b0, 2'b00, st[2:0]};
            end else begin                                       // R7 R8
                e.lvl = st[0] ? 2'b01 : 2'b00;
                e.st  = {st[6:3], st[1], 1'b0, 1'b0};
            end
        end
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ret_valid = 1'b0;
        end
    endtask

    // Monitor: every response is compared with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({rsp_commit, rsp_illegal, rsp_misaligned} == e.flags,
                    "R1 R2 R4 R5 flags", 64'({rsp_commit, rsp_illegal, rsp_misaligned}), 64'(e.flags));
                chk(rsp_pc == e.pc, "R3 pc", 64'(rsp_pc), 64'(e.pc));
                chk(rsp_priv == e.lvl, "R8 R9 level", 64'(rsp_priv), 64'(e.lvl));
                chk({rsp_mie, rsp_mpie, rsp_mpp, rsp_sie, rsp_spie, rsp_spp} == e.st,
                    "R6 R7 R9 status", 64'({rsp_mie, rsp_mpie, rsp_mpp, rsp_sie, rsp_spie, rsp_spp}), 64'(e.st));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog expired actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(rsp_valid == 1'b0, "R10 reset valid", 64'(rsp_valid), 64'd0);
        chk(rsp_priv == 2'b11, "R10 reset level", 64'(rsp_priv), 64'd3);
        chk({rsp_mie, rsp_mpie, rsp_mpp, rsp_sie, rsp_spie, rsp_spp} == 7'd0, "R10 reset status",
            64'({rsp_mie, rsp_mpie, rsp_mpp, rsp_sie, rsp_spie, rsp_spp}), 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R6 R8: machine returns into S, H (remapped to U) and U
        issue(1'b0, 2'b11, 7'b0_1_01_1_1_1, 32'h0000_4000, 32'h0000_8000, 1'b0);
        issue(1'b0, 2'b11, 7'b1_1_10_0_1_0, 32'h0000_4004, 32'h0000_8000, 1'b0);
        issue(1'b0, 2'b11, 7'b1_0_00_1_0_1, 32'h0000_4008, 32'h0000_8000, 1'b0);
        idle(2);
        // R1 R9: machine return from S and U
        issue(1'b0, 2'b01, 7'b1_1_11_1_1_1, 32'h0000_4000, 32'h0000_8000, 1'b0);
        issue(1'b0, 2'b00, 7'b0_1_01_0_1_0, 32'h0000_4000, 32'h0000_8000, 1'b0);
        // R2 R7: supervisor returns
        issue(1'b1, 2'b00, 7'b1_0_11_0_1_1, 32'h0000_4000, 32'h0000_8000, 1'b0);
        issue(1'b1, 2'b01, 7'b1_0_11_0_1_1, 32'h0000_4000, 32'h0000_8010, 1'b0);
        issue(1'b1, 2'b01, 7'b0_1_01_1_0_0, 32'h0000_4000, 32'h0000_8020, 1'b0);
        issue(1'b1, 2'b11, 7'b0_0_00_0_1_1, 32'h0000_4000, 32'h0000_8030, 1'b0);
        idle(1);
        // R4: alignment depends on compressed support
        issue(1'b0, 2'b11, 7'b0_1_11_0_0_0, 32'h0000_4002, 32'h0000_8000, 1'b0);
        issue(1'b0, 2'b11, 7'b0_1_11_0_0_0, 32'h0000_4002, 32'h0000_8000, 1'b1);
        issue(1'b1, 2'b01, 7'b0_0_00_0_1_1, 32'h0000_4000, 32'h0000_8001, 1'b0);
        issue(1'b1, 2'b01, 7'b0_0_00_0_1_1, 32'h0000_4000, 32'h0000_8003, 1'b1);
        // R5: both faults at once; illegal wins
        issue(1'b1, 2'b00, 7'b1_1_01_1_1_1, 32'h0000_4000, 32'h0000_8002, 1'b0);
        issue(1'b0, 2'b01, 7'b1_1_01_1_1_1, 32'h0000_4003, 32'h0000_8000, 1'b0);
        idle(2);
        // R10: quiet outputs after an idle cycle
        chk({rsp_valid, rsp_commit, rsp_illegal, rsp_misaligned} == 4'd0, "R10 idle quiet",
            64'({rsp_valid, rsp_commit, rsp_illegal, rsp_misaligned}), 64'd0);

        // Sweep of kinds, levels, previous levels, enables and alignments
        for (int k = 0; k < 2; k++)
            for (int l = 0; l < 4; l++)
                for (int p = 0; p < 4; p++)
                    for (int b = 0; b < 2; b++)
                        for (int a = 0; a < 4; a++)
                            issue(k[0], l[1:0], {b[0], ~b[0], p[1:0], ~b[0], b[0], p[0]},
                                  32'h0001_0000 + 32'(a), 32'h0002_0000 + 32'(3 - a), a[0] & p[1]);
        idle(3);
        chk(q.size() == 0, "R10 all responses seen", 64'(q.size()), 64'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule